// File: doc/BRIEF.md
# Vector Length Control Unit

This block owns the active element count of a length-agnostic vector datapath. Software hands it the number of elements it still has to process; the block grants the smaller of that count and the hardware maximum vector length, keeps the grant as the active length and returns it, so the loop can step its pointers and reduce its remaining count by exactly the granted amount. The grant may be any value from zero to the maximum. It is not rounded to a power of two or to a lane multiple.

From the active length the block drives a per-lane enable vector: lane i is on only when i is below the active length. An optional external predicate can be ANDed into that vector. A grant of zero turns every later vector operation into a no-op. A separate shrink port lets a truncated load (one that stopped early) cut the active length down. It never raises it.

The request side and the response side each use a valid/ready handshake. The response holds one entry. It appears on the cycle after the request is accepted and stays until it is taken.

Top module: `vlen_ctrl`

## Requirements
- R1: On an accepted request, the value returned on `rsp_len` is min(`req_count`, MVL). With MVL = 12, a count of 5 returns 5, so the grant need not be a power of two or a lane multiple.
- R2: On the cycle after a request is accepted, `active_len` equals the granted value.
- R3: A requested count of 0 sets `active_len` to 0, and every bit of `lane_en` is then 0.
- R4: Bit i of `lane_en` is 1 exactly when i < `active_len` and, if `ext_mask_use` is 1, bit i of `ext_mask` is also 1. When `ext_mask_use` is 0, `ext_mask` has no effect.
- R5: `rsp_valid` rises on the cycle after a request is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_len` does not change.
- R6: `req_ready` is 1 exactly when no response is pending or the pending response is taken in the same cycle.
- R7: A shrink (`trunc_valid` = 1) loads `trunc_len` into `active_len` only when 0 < `trunc_len` < `active_len`. Any other shrink leaves `active_len` unchanged.
- R8: When a request is accepted in the same cycle as a shrink, the request's grant wins.
- R9: After reset, `active_len` is 0, `rsp_valid` is 0 and `lane_en` is all zeros.
- R10: Requested counts above MVL, including the largest value the count field can hold, clamp to MVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Set-length request valid |
| req_ready | output | 1 | Set-length request can be accepted |
| req_count | input | CNT_W | Elements still to process |
| rsp_valid | output | 1 | Granted length available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_len | output | LEN_W | Granted length |
| trunc_valid | input | 1 | Shrink request from a truncated load |
| trunc_len | input | LEN_W | Proposed shorter length |
| ext_mask_use | input | 1 | Apply the external predicate |
| ext_mask | input | MVL | External per-lane predicate |
| active_len | output | LEN_W | Current active vector length |
| lane_en | output | MVL | Per-lane enable driven to the lanes |

## Verification
The assertions check on every cycle that the active length never exceeds MVL, that an accepted grant lands in both the active length and the response, that a pending response holds, that `req_ready` drops under backpressure, that ignored shrinks leave the length untouched, and that the enable count never exceeds the active length. Other properties need the bench's scenarios against its own model. These are the exact clamp values at the edges (zero, exactly MVL, the all-ones count), the exact per-lane pattern under an external predicate, the priority of a grant over a same-cycle shrink, and the long mixed random sequences of requests, shrinks and backpressure.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  // Source of the active-length update on a given cycle
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_GRANT = 2'd1,
    UPD_TRUNC = 2'd2
  } upd_src_e;
endpackage

// File: rtl/vlen_clamp.sv
module vlen_clamp #(
  parameter int CNT_W = 16,
  parameter int MVL   = 12,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic [LEN_W-1:0] granted
);
  localparam logic [CNT_W-1:0] MVL_C = CNT_W'(MVL);

  function automatic logic [LEN_W-1:0] grant_of(input logic [CNT_W-1:0] c);
    if (c > MVL_C) return LEN_W'(MVL);
    return LEN_W'(c);
  endfunction

  assign granted = grant_of(count);
endmodule

// File: rtl/vlen_state.sv
module vlen_state
  import vlen_pkg::*;
#(
  parameter int MVL   = 12,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             trunc_valid,
  input  logic [LEN_W-1:0] trunc_len,
  output logic [LEN_W-1:0] active_len,
  output upd_src_e         upd_src
);
  logic [LEN_W-1:0] len_q;
  logic             trunc_ok;

  function automatic logic shrink_allowed(input logic [LEN_W-1:0] nl,
                                          input logic [LEN_W-1:0] cur);
    return (nl != '0) && (nl < cur);
  endfunction

  assign trunc_ok = trunc_valid && shrink_allowed(trunc_len, len_q);

  always_comb begin
    if (load)          upd_src = UPD_GRANT;
    else if (trunc_ok) upd_src = UPD_TRUNC;
    else               upd_src = UPD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else begin
      case (upd_src)
        UPD_GRANT: len_q <= load_len;
        UPD_TRUNC: len_q <= trunc_len;
        default:   len_q <= len_q;
      endcase
    end
  end

  assign active_len = len_q;

  // R1: active length never above the maximum
  assert_len_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active_len <= LEN_W'(MVL));

  // R8: a grant always lands, shrink or not
  assert_grant_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_len == $past(load_len));

  // R7: an accepted shrink lands
  assert_trunc_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_src == UPD_TRUNC) |=> active_len == $past(trunc_len));

  // R7: out-of-range shrink leaves length untouched
  assert_trunc_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trunc_valid && !load && (trunc_len == '0 || trunc_len >= active_len))
      |=> $stable(active_len));
endmodule

// File: rtl/vlen_rsp_slot.sv
module vlen_rsp_slot #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [LEN_W-1:0] rsp_len,
  output logic             slot_free
);
  logic             vld_q;
  logic [LEN_W-1:0] len_q;
  logic             pop;

  assign pop       = vld_q && rsp_ready;
  assign slot_free = !vld_q || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      len_q <= '0;
    end else begin
      if (push) begin
        vld_q <= 1'b1;
        len_q <= push_len;
      end else if (pop) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_len   = len_q;

  // R5: a pushed grant shows on the next cycle
  assert_push_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rsp_valid && rsp_len == $past(push_len));

  // R5: pending response is held under backpressure
  assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_len));
endmodule

// File: rtl/vlen_mask.sv
module vlen_mask #(
  parameter int MVL   = 12,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] active_len,
  input  logic             ext_mask_use,
  input  logic [MVL-1:0]   ext_mask,
  output logic [MVL-1:0]   lane_en
);
  logic [MVL-1:0] tail_en;

  function automatic logic lane_inside(input logic [LEN_W-1:0] idx,
                                       input logic [LEN_W-1:0] len);
    return idx < len;
  endfunction

  for (genvar i = 0; i < MVL; i++) begin : g_lane
    localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
    assign tail_en[i] = lane_inside(IDX, active_len);
    assign lane_en[i] = tail_en[i] && (!ext_mask_use || ext_mask[i]);
  end

  // R4: never more lanes on than the active length
  assert_mask_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en) <= int'(active_len));

  // R4: without the external predicate, exactly active_len lanes are on
  assert_mask_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mask_use |-> $countones(lane_en) == int'(active_len));
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int MVL   = 12,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] req_count,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [LEN_W-1:0] rsp_len,
  input  logic             trunc_valid,
  input  logic [LEN_W-1:0] trunc_len,
  input  logic             ext_mask_use,
  input  logic [MVL-1:0]   ext_mask,
  output logic [LEN_W-1:0] active_len,
  output logic [MVL-1:0]   lane_en
);
  logic             accept;
  logic             slot_free;
  logic [LEN_W-1:0] granted;
  upd_src_e         upd_src;

  assign req_ready = slot_free;
  assign accept    = req_valid && slot_free;

  vlen_clamp #(.CNT_W(CNT_W), .MVL(MVL), .LEN_W(LEN_W)) u_clamp (
    .count   (req_count),
    .granted (granted)
  );

  vlen_state #(.MVL(MVL), .LEN_W(LEN_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_len    (granted),
    .trunc_valid (trunc_valid),
    .trunc_len   (trunc_len),
    .active_len  (active_len),
    .upd_src     (upd_src)
  );

  vlen_rsp_slot #(.LEN_W(LEN_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_len  (granted),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_len   (rsp_len),
    .slot_free (slot_free)
  );

  vlen_mask #(.MVL(MVL), .LEN_W(LEN_W)) u_mask (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_len   (active_len),
    .ext_mask_use (ext_mask_use),
    .ext_mask     (ext_mask),
    .lane_en      (lane_en)
  );

  // R2: accepted grant appears both as active length and as response
  assert_accept_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid && active_len == rsp_len);

  // R3: zero request gives an all-off enable vector
  assert_zero_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_count == '0) |=> lane_en == '0);

  // R6: no acceptance while the response is stuck
  assert_ready_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R10: a count above the maximum yields the maximum
  assert_clamp_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_count > CNT_W'(MVL)) |=> rsp_len == LEN_W'(MVL));

  // R9: idle state right after reset release
  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid && active_len == '0);
endmodule

// File: tb/tb_vlen_ctrl.sv
module tb_vlen_ctrl;
  localparam int CNT_W = 16;
  localparam int MVL   = 12;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [CNT_W-1:0] req_count;
  logic             rsp_valid;
  logic             rsp_ready;
  logic [LEN_W-1:0] rsp_len;
  logic             trunc_valid;
  logic [LEN_W-1:0] trunc_len;
  logic             ext_mask_use;
  logic [MVL-1:0]   ext_mask;
  logic [LEN_W-1:0] active_len;
  logic [MVL-1:0]   lane_en;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int m_act = 0;
  int m_rl  = 0;
  bit m_rv  = 1'b0;

  always #2 clk = ~clk;

  vlen_ctrl #(.CNT_W(CNT_W), .MVL(MVL), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_count(req_count),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
    .trunc_valid(trunc_valid), .trunc_len(trunc_len),
    .ext_mask_use(ext_mask_use), .ext_mask(ext_mask),
    .active_len(active_len), .lane_en(lane_en)
  );

  function automatic int want_grant(input int cnt);
    return (cnt < MVL) ? cnt : MVL;
  endfunction

  function automatic int want_mask(input int len, input logic [MVL-1:0] ext, input bit use_ext);
    int r = 0;
    for (int i = 0; i < MVL; i++)
      if (i < len && (!use_ext || ext[i])) r |= (1 << i);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one clock edge, update model, compare at the following negedge
  task automatic step(input string ctx);
    bit acc;
    @(posedge clk);
    acc = req_valid && (!m_rv || rsp_ready);
    if (acc) begin
      m_act = want_grant(int'(req_count));
      m_rl  = m_act;
      m_rv  = 1'b1;
    end else begin
      if (m_rv && rsp_ready) m_rv = 1'b0;
      if (trunc_valid && trunc_len != 0 && int'(trunc_len) < m_act) m_act = int'(trunc_len);
    end
    @(negedge clk);
    chk({"R2/R7 active_len ", ctx}, int'(active_len), m_act);
    chk({"R5 rsp_valid ", ctx}, int'(rsp_valid), int'(m_rv));
    if (m_rv) chk({"R1 rsp_len ", ctx}, int'(rsp_len), m_rl);
    chk({"R4 lane_en ", ctx}, int'(lane_en), want_mask(m_act, ext_mask, ext_mask_use));
    chk({"R6 req_ready ", ctx}, int'(req_ready), int'(!m_rv || rsp_ready));
  endtask

  task automatic idle_inputs();
    req_valid   = 1'b0;
    trunc_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_count = '0; rsp_ready = 1'b1;
    trunc_valid = 1'b0; trunc_len = '0; ext_mask_use = 1'b0; ext_mask = '0;
    repeat (3) @(negedge clk);
    chk("R9 active_len", int'(active_len), 0);
    chk("R9 rsp_valid", int'(rsp_valid), 0);
    chk("R9 lane_en", int'(lane_en), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: non power of two grant
    req_valid = 1'b1; req_count = 16'd5; step("R1 count5");
    chk("R1 grant five", int'(rsp_len), 5);
    idle_inputs(); step("idle");

    // R3: zero request
    req_valid = 1'b1; req_count = 16'd0; step("R3 zero");
    chk("R3 lanes off", int'(lane_en), 0);
    idle_inputs(); step("idle");

    // R10: all-ones count clamps
    req_valid = 1'b1; req_count = 16'hFFFF; step("R10 max");
    chk("R10 clamp", int'(active_len), MVL);
    req_count = 16'd12; step("R1 exact");
    chk("R1 exact mvl", int'(rsp_len), MVL);
    idle_inputs(); step("idle");

    // R7: shrink cases
    trunc_valid = 1'b1; trunc_len = 4'd12; step("R7 equal");
    chk("R7 equal ignored", int'(active_len), 12);
    trunc_len = 4'd0; step("R7 zero");
    chk("R7 zero ignored", int'(active_len), 12);
    trunc_len = 4'd13; step("R7 larger");
    chk("R7 larger ignored", int'(active_len), 12);
    trunc_len = 4'd7; step("R7 shrink");
    chk("R7 shrink applied", int'(active_len), 7);
    idle_inputs(); step("idle");

    // R8: grant beats same-cycle shrink
    req_valid = 1'b1; req_count = 16'd3; trunc_valid = 1'b1; trunc_len = 4'd1; step("R8 race");
    chk("R8 grant wins", int'(active_len), 3);
    idle_inputs(); step("idle");

    // R5/R6: backpressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_count = 16'd9; step("R5 push");
    req_count = 16'd4; step("R6 blocked");
    chk("R6 ready low", int'(req_ready), 0);
    chk("R5 len held", int'(rsp_len), 9);
    step("R5 still held");
    rsp_ready = 1'b1; step("R6 release");
    chk("R6 second grant", int'(active_len), 4);
    idle_inputs(); step("idle");

    // R4: external predicate
    ext_mask_use = 1'b1; ext_mask = 12'hA5A;
    req_valid = 1'b1; req_count = 16'd10; step("R4 ext");
    chk("R4 predicated", int'(lane_en), 32'h25A);
    ext_mask_use = 1'b0; idle_inputs(); step("R4 ext off");
    chk("R4 predicate ignored", int'(lane_en), 32'h3FF);

    // random mix
    for (int k = 0; k < 600; k++) begin
      req_valid    = ($urandom % 3) == 0;
      req_count    = (($urandom % 4) == 0) ? CNT_W'($urandom) : CNT_W'($urandom % 16);
      trunc_valid  = ($urandom % 3) == 0;
      trunc_len    = LEN_W'($urandom);
      rsp_ready    = ($urandom % 4) != 0;
      ext_mask_use = ($urandom % 2) == 0;
      ext_mask     = MVL'($urandom);
      step("random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule